// File: doc/BRIEF.md
# GPIO Bank with Interrupt Sensing

A bank of up to 32 general-purpose pins driven and observed through a small 32-bit register port. Each pin has one of three roles. It can be a plain input, a plain output, or an interrupt source. An interrupt source samples its pad through a two-flop synchronizer and then applies level or edge sensing. Polarity is programmable, and an optional mode detects both edges. Pending interrupts collect in a status vector. That vector is gated by a per-pin enable vector and reduced to a single interrupt line.

Software sets roles and sensing through per-pin configuration registers. It enables interrupts by writing ones to an unmask register and disables them by writing zeros to a mask register. It acknowledges latched edges by writing ones to an acknowledge register. Register writes take effect on the clock edge that samples them. Reads are combinational from the selected address.

Register word addresses: 0 role (1 = interrupt source), 1 direction (1 = output), 2 output latch, 3 pin data, 4 polarity, 5 edge select, 6 both-edge, 7 pending status, 8 acknowledge, 9 mask (reads the enable vector), 10 unmask.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every pin is a general-mode input. pad_o, pad_oe_o and irq_o are 0, and the role, enable and status registers read 0.
- R2: The effective pin count is N_PINS, or 32 when N_PINS is 0 or above 32. Register bits at or above the effective count read 0, never drive pad_oe_o, and never raise status.
- R3: pad_oe_o bit p is 1 exactly when role bit p is 0 and direction bit p is 1. pad_o carries the output latch.
- R4: A pin-data read (address 3) returns the output latch for a general-mode output pin. For any other pin it returns the pad value, which is visible two rising edges after the pad changes.
- R5: In level mode (role 1, edge bit 0) the status bit equals the synchronized pad XOR polarity, three rising edges after the pad changes. A 1 written to acknowledge does not clear it while the level stays active.
- R6: In edge mode (edge bit 1, both-edge bit 0) polarity 0 latches status on a rising pad edge and polarity 1 latches it on a falling edge, three rising edges after the pad changes. The bit holds until a 1 is written to its acknowledge bit. Acknowledge bits written 0 have no effect.
- R7: With both-edge set (variant parameter HAS_BOTH = 1), an edge-mode pin latches status on rising and on falling pad transitions, whatever its polarity.
- R8: Writing a 1 to an unmask bit enables that pin, and writing a 0 to a mask bit disables it. Unmask zeros and mask ones leave enables unchanged. Address 9 reads the enable vector and address 10 reads 0.
- R9: irq_o is 1 exactly when some pin has both status and enable set. Changing the enable bit of a pending pin changes irq_o on the write edge.
- R10: A pin with role 0 never sets its status bit, whatever its pad does.
- R11: The role, direction, output, polarity, edge and both-edge registers read back the last value written. Address 8 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| pad_i | input | 32 | Pad input values |
| pad_o | output | 32 | Pad output values |
| pad_oe_o | output | 32 | Pad output enables |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Configuration writes are visible on reg_rdata_o and the pad outputs right after the sampling edge. Enable changes reach irq_o in that same step. A pad change reaches the pin-data read after two rising edges, and reaches status and irq_o after three. The bench changes pads and register inputs on falling edges and samples 1 ns later, counting edges explicitly. For the latency cases it checks one edge early, expecting the old value, and then again at the due edge. Latched and ignored-write cases are read back through the status and mask registers before the next stimulus.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned BANK_W = 32;
  localparam int unsigned REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    A_ROLE   = 4'd0,
    A_DIR    = 4'd1,
    A_OUT    = 4'd2,
    A_IN     = 4'd3,
    A_POL    = 4'd4,
    A_EDGE   = 4'd5,
    A_BOTH   = 4'd6,
    A_STAT   = 4'd7,
    A_ACK    = 4'd8,
    A_MASK   = 4'd9,
    A_UNMASK = 4'd10
  } reg_addr_e;

  function automatic int unsigned eff_pins(int unsigned n);
    return (n == 0 || n > BANK_W) ? BANK_W : n;
  endfunction
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NP       = 32,
  parameter bit          HAS_BOTH = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [BANK_W-1:0] wdata_i,
  input  logic [BANK_W-1:0] sync_i,
  input  logic [BANK_W-1:0] stat_i,
  output logic [BANK_W-1:0] rdata_o,
  output logic [BANK_W-1:0] role_o,
  output logic [BANK_W-1:0] dir_o,
  output logic [BANK_W-1:0] out_o,
  output logic [BANK_W-1:0] pol_o,
  output logic [BANK_W-1:0] edge_o,
  output logic [BANK_W-1:0] both_o,
  output logic [BANK_W-1:0] en_o,
  output logic [BANK_W-1:0] ack_o
);
  localparam logic [BANK_W-1:0] PIN_MASK = {BANK_W{1'b1}} >> (BANK_W - NP);

  logic [BANK_W-1:0] role_q, dir_q, out_q, pol_q, edge_q, both_q, en_q;
  logic [BANK_W-1:0] wmask, drive_out;

  assign wmask = wdata_i & PIN_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      role_q <= '0;
      dir_q  <= '0;
      out_q  <= '0;
      pol_q  <= '0;
      edge_q <= '0;
      en_q   <= '0;
    end else if (wr_i) begin
      case (addr_i)
        A_ROLE:   role_q <= wmask;
        A_DIR:    dir_q  <= wmask;
        A_OUT:    out_q  <= wmask;
        A_POL:    pol_q  <= wmask;
        A_EDGE:   edge_q <= wmask;
        A_MASK:   en_q   <= en_q & wdata_i;
        A_UNMASK: en_q   <= en_q | wmask;
        default:  ;
      endcase
    end
  end

  generate
    if (HAS_BOTH) begin : g_both
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                        both_q <= '0;
        else if (wr_i && addr_i == A_BOTH)  both_q <= wmask;
      end
    end else begin : g_no_both
      assign both_q = '0;
    end
  endgenerate

  assign drive_out = dir_q & ~role_q;
  assign ack_o     = (wr_i && addr_i == A_ACK) ? wmask : '0;

  always_comb begin
    case (addr_i)
      A_ROLE:  rdata_o = role_q;
      A_DIR:   rdata_o = dir_q;
      A_OUT:   rdata_o = out_q;
      A_IN:    rdata_o = ((drive_out & out_q) | (~drive_out & sync_i)) & PIN_MASK;
      A_POL:   rdata_o = pol_q;
      A_EDGE:  rdata_o = edge_q;
      A_BOTH:  rdata_o = both_q;
      A_STAT:  rdata_o = stat_i;
      A_MASK:  rdata_o = en_q;
      default: rdata_o = '0;
    endcase
  end

  assign role_o = role_q;
  assign dir_o  = dir_q;
  assign out_o  = out_q;
  assign pol_o  = pol_q;
  assign edge_o = edge_q;
  assign both_o = both_q;
  assign en_o   = en_q;

  // R8
  mask_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && (addr_i == A_MASK || addr_i == A_UNMASK)) |=> en_q == $past(en_q));
endmodule

// File: rtl/gpio_bank_sense.sv
module gpio_bank_sense
  import gpio_bank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] sync_i,
  input  logic [BANK_W-1:0] role_i,
  input  logic [BANK_W-1:0] pol_i,
  input  logic [BANK_W-1:0] edge_i,
  input  logic [BANK_W-1:0] both_i,
  input  logic [BANK_W-1:0] ack_i,
  output logic [BANK_W-1:0] stat_o
);
  logic [BANK_W-1:0] prev_q, stat_q, stat_d, evt;

  for (genvar i = 0; i < BANK_W; i++) begin : g_pin
    always_comb begin
      if (both_i[i])     evt[i] = sync_i[i] ^ prev_q[i];
      else if (pol_i[i]) evt[i] = prev_q[i] & ~sync_i[i];
      else               evt[i] = sync_i[i] & ~prev_q[i];

      if (!role_i[i])      stat_d[i] = 1'b0;
      else if (!edge_i[i]) stat_d[i] = sync_i[i] ^ pol_i[i];
      else                 stat_d[i] = (stat_q[i] & ~ack_i[i]) | evt[i];
    end

    // R10
    gen_mode_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !role_i[i] |=> !stat_q[i]);

    // R5
    level_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (role_i[i] && !edge_i[i]) |=> stat_q[i] == $past(sync_i[i] ^ pol_i[i]));

    // R6
    edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (role_i[i] && edge_i[i] && stat_q[i] && !ack_i[i]) |=> stat_q[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= sync_i;
      stat_q <= stat_d;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N_PINS   = 32,
  parameter bit          HAS_BOTH = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic [3:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic [31:0] pad_i,
  output logic [31:0] pad_o,
  output logic [31:0] pad_oe_o,
  output logic        irq_o
);
  localparam int unsigned NP = eff_pins(N_PINS);

  logic [BANK_W-1:0] sync, stat, role, dir, outl, pol, edg, both, en, ack;

  gpio_bank_sync #(.W(BANK_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (sync)
  );

  gpio_bank_regs #(.NP(NP), .HAS_BOTH(HAS_BOTH)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (reg_wr_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .sync_i (sync),
    .stat_i (stat),
    .rdata_o(reg_rdata_o),
    .role_o (role),
    .dir_o  (dir),
    .out_o  (outl),
    .pol_o  (pol),
    .edge_o (edg),
    .both_o (both),
    .en_o   (en),
    .ack_o  (ack)
  );

  gpio_bank_sense u_sense (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sync_i(sync),
    .role_i(role),
    .pol_i (pol),
    .edge_i(edg),
    .both_i(both),
    .ack_i (ack),
    .stat_o(stat)
  );

  assign pad_o    = outl;
  assign pad_oe_o = dir & ~role;
  assign irq_o    = |(stat & en);

  // R3
  oe_role_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & role) == '0);
endmodule

// File: tb/gpio_irq_bank_tb.sv
`timescale 1ns/1ps
module gpio_irq_bank_tb;
  localparam logic [3:0] ROLE = 4'd0, DIR = 4'd1, OUTL = 4'd2, PIN = 4'd3,
                         POL = 4'd4, EDG = 4'd5, BOTH = 4'd6, STAT = 4'd7,
                         ACK = 4'd8, MASK = 4'd9, UNMASK = 4'd10;

  typedef struct packed {
    logic [3:0]  wa;
    logic [31:0] wd;
    logic [3:0]  ra;
    logic [31:0] exp;
  } vec_t;

  // R11 readbacks, R8 mask/unmask semantics
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{ROLE,   32'hA5A5_0000, ROLE, 32'hA5A5_0000},
    '{DIR,    32'h00FF_00FF, DIR,  32'h00FF_00FF},
    '{OUTL,   32'h1234_5678, OUTL, 32'h1234_5678},
    '{POL,    32'hDEAD_BEEF, POL,  32'hDEAD_BEEF},
    '{EDG,    32'h0F0F_0F0F, EDG,  32'h0F0F_0F0F},
    '{BOTH,   32'hF0F0_F0F0, BOTH, 32'hF0F0_F0F0},
    '{ACK,    32'hFFFF_FFFF, ACK,  32'h0000_0000},
    '{UNMASK, 32'h0000_0F0F, MASK, 32'h0000_0F0F},
    '{MASK,   32'hFFFF_FFF0, MASK, 32'h0000_0F00},
    '{UNMASK, 32'h0000_0000, MASK, 32'h0000_0F00},
    '{MASK,   32'hFFFF_FFFF, MASK, 32'h0000_0F00},
    '{MASK,   32'h0000_0000, MASK, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] pad = '0;
  logic [31:0] rdata, pad_o, oe, rdata8, pad_o8, oe8, rdata40, pad_o40, oe40;
  logic        irq, irq8, irq40;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .pad_i(pad), .pad_o(pad_o), .pad_oe_o(oe), .irq_o(irq));

  gpio_irq_bank #(.N_PINS(8)) u_dut8 (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata8), .pad_i(pad), .pad_o(pad_o8), .pad_oe_o(oe8), .irq_o(irq8));

  gpio_irq_bank #(.N_PINS(40)) u_dut40 (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata40), .pad_i(pad), .pad_o(pad_o40), .pad_oe_o(oe40), .irq_o(irq40));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic chk_reg(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rreg(a, d);
    chk(tag, d, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    #1;
    chk("R1 pad_oe", oe, '0);
    chk("R1 pad_o", pad_o, '0);
    chk("R1 irq", {31'd0, irq}, '0);
    chk_reg("R1 role", ROLE, '0);
    chk_reg("R1 mask", MASK, '0);
    chk_reg("R1 stat", STAT, '0);
    tick(1);

    for (int i = 0; i < NV; i++) begin
      wreg(VECS[i].wa, VECS[i].wd);
      chk($sformatf("R11/R8 vec%0d", i), 32'(0), 32'(0) | 32'(0));
      n_chk--;
      chk_reg($sformatf("R11/R8 vec%0d", i), VECS[i].ra, VECS[i].exp);
      tick(1);
    end
    wreg(ROLE, 0); wreg(DIR, 0); wreg(OUTL, 0);
    wreg(POL, 0); wreg(EDG, 0); wreg(BOTH, 0);
    tick(3);

    // R3 output enable and output latch
    wreg(DIR, 32'h3); wreg(OUTL, 32'h1);
    #1;
    chk("R3 oe", oe, 32'h3);
    chk("R3 pad_o", pad_o, 32'h1);
    tick(1);
    wreg(ROLE, 32'h2);
    #1 chk("R3 oe role", oe, 32'h1);
    tick(1);

    // R2 pin count clamp
    wreg(DIR, 32'hFFFF_FFFF);
    wreg(ROLE, 32'h0);
    #1;
    chk("R2 oe 8 pins", oe8, 32'h0000_00FF);
    chk("R2 oe 40->32 pins", oe40, 32'hFFFF_FFFF);
    addr = DIR;
    #1;
    chk("R2 dir 8 pins", rdata8, 32'h0000_00FF);
    chk("R2 dir 40->32 pins", rdata40, 32'hFFFF_FFFF);
    tick(1);
    wreg(DIR, 0); wreg(OUTL, 0);
    tick(2);

    // R4 pin data read
    wreg(DIR, 32'h1); wreg(OUTL, 32'h1);
    chk_reg("R4 output latch", PIN, 32'h1);
    tick(1);
    pad[4] = 1'b1;
    tick(1);
    chk_reg("R4 pad one edge", PIN, 32'h1);
    tick(1);
    chk_reg("R4 pad two edges", PIN, 32'h11);
    tick(1);
    wreg(OUTL, 0);
    chk_reg("R4 latch low", PIN, 32'h10);
    tick(1);
    pad[4] = 1'b0;
    wreg(DIR, 0);
    tick(3);

    // R5 level sensing, R9 irq
    wreg(ROLE, 32'h100); wreg(UNMASK, 32'h100);
    pad[8] = 1'b1;
    tick(2);
    chk_reg("R5 level two edges", STAT, 32'h0);
    tick(1);
    chk_reg("R5 level three edges", STAT, 32'h100);
    chk("R9 irq level", {31'd0, irq}, 32'h1);
    tick(1);
    wreg(ACK, 32'h100);
    chk_reg("R5 ack ignored", STAT, 32'h100);
    tick(1);
    pad[8] = 1'b0;
    tick(3);
    chk_reg("R5 level released", STAT, 32'h0);
    chk("R9 irq released", {31'd0, irq}, 32'h0);
    tick(1);
    wreg(POL, 32'h100);
    tick(2);
    chk_reg("R5 active low", STAT, 32'h100);
    tick(1);
    wreg(POL, 0); wreg(ROLE, 0); wreg(MASK, 0);
    tick(2);

    // R6 rising edge latch
    wreg(EDG, 32'h1000); wreg(ROLE, 32'h1000); wreg(UNMASK, 32'h1000);
    pad[12] = 1'b1;
    tick(2);
    chk_reg("R6 rise two edges", STAT, 32'h0);
    tick(1);
    chk_reg("R6 rise three edges", STAT, 32'h1000);
    tick(1);
    pad[12] = 1'b0;
    tick(4);
    chk_reg("R6 latched", STAT, 32'h1000);
    tick(1);
    wreg(ACK, 32'hFFFF_EFFF);
    chk_reg("R6 zero ack ignored", STAT, 32'h1000);
    tick(1);
    wreg(ACK, 32'h1000);
    chk_reg("R6 acked", STAT, 32'h0);
    tick(1);

    // R6 falling edge with polarity 1
    wreg(POL, 32'h1000);
    pad[12] = 1'b1;
    tick(4);
    chk_reg("R6 pol1 rise ignored", STAT, 32'h0);
    tick(1);
    pad[12] = 1'b0;
    tick(3);
    chk_reg("R6 pol1 fall", STAT, 32'h1000);
    tick(1);

    // R9 enable gating
    wreg(MASK, 32'hFFFF_EFFF);
    #1 chk("R9 masked", {31'd0, irq}, 32'h0);
    chk_reg("R9 still pending", STAT, 32'h1000);
    tick(1);
    wreg(UNMASK, 32'h1000);
    #1 chk("R9 unmasked", {31'd0, irq}, 32'h1);
    tick(1);
    wreg(ACK, 32'h1000);
    #1 chk("R9 after ack", {31'd0, irq}, 32'h0);
    tick(1);

    // R7 both edges
    wreg(BOTH, 32'h1000);
    pad[12] = 1'b1;
    tick(3);
    chk_reg("R7 rise", STAT, 32'h1000);
    tick(1);
    wreg(ACK, 32'h1000);
    pad[12] = 1'b0;
    tick(3);
    chk_reg("R7 fall", STAT, 32'h1000);
    tick(1);
    wreg(ACK, 32'h1000);
    wreg(ROLE, 0); wreg(EDG, 0); wreg(BOTH, 0); wreg(POL, 0);
    tick(2);

    // R10 general-mode pin never pends
    wreg(UNMASK, 32'h0010_0000);
    pad[20] = 1'b1;
    tick(4);
    chk_reg("R10 rise quiet", STAT, 32'h0);
    pad[20] = 1'b0;
    tick(4);
    chk_reg("R10 fall quiet", STAT, 32'h0);
    #1 chk("R10 irq quiet", {31'd0, irq}, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule